// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master for external Ethernet PHYs. It exposes four 32-bit registers on a simple word interface: configuration/status, control, data and address. Frames start as side effects of register writes. Writing the address register in Clause 45 mode sends an address frame. Writing the data register sends a write frame. Writing the control register with its read-go bit set sends a read frame. Software polls the busy flag, which is set from the accepting clock edge until the last bit period of the frame ends.

MDC is derived from the system clock. One MDC period lasts 2*div+1 clock cycles: MDC is high for div+1 cycles and low for div cycles. It runs only while a frame is in flight and rests low otherwise. The master presents each new bit as MDC rises. It samples returned bits on the clock edge that closes a bit period, which is the edge on which MDC rises again. During the turnaround and data phases of a read it releases the line. It flags a read error when the PHY does not pull the second turnaround bit low.

The frame engine is a state machine with five states:

| State | Meaning |
|---|---|
| ST_IDLE | No frame in flight |
| ST_PRE | 32 preamble ones |
| ST_HDR | 14 header bits: start, opcode, port, device |
| ST_TA | 2 turnaround bits |
| ST_DATA | 16 data bits |

The transitions are:
- ST_IDLE goes to ST_PRE on a launch.
- ST_IDLE goes straight to ST_HDR on a launch when preamble suppression is on.
- ST_PRE goes to ST_HDR after bit 31.
- ST_HDR goes to ST_TA after bit 13.
- ST_TA goes to ST_DATA after bit 1.
- ST_DATA goes back to ST_IDLE after bit 15.

Each of these moves happens only on the last clock cycle of a bit period.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC, the output enable and the line output are low, busy is 0, and all four registers read as zero.
- R2: Register map, selected by reg_sel. Index 0 is configuration/status: div in [7:0], preamble-suppress in bit 8, Clause 45 mode in bit 9, read error in bit 30, busy in bit 31. Index 1 is control: port address in [4:0], device/register address in [9:5], read-go in bit 15. Index 2 is data in [15:0]. Index 3 is address in [15:0]. Unlisted bits read as 0.
- R3: While busy, MDC repeats with a period of 2*div+1 cycles, high for the first div+1 cycles of each bit period and low for the rest. Outside a frame MDC stays low.
- R4: Every frame begins with 32 driven ones unless preamble-suppress is set. When it is set, the header follows the launch directly.
- R5: A Clause 22 header is sent MSB first as start, opcode, port[4:0], register[4:0]. The start code is 01. The opcode is 01 for write and 10 for read.
- R6: In Clause 45 mode, a write to the address register starts a frame with start 00 and opcode 00, turnaround 10, and the 16 stored address bits. In Clause 22 mode the same write only stores the value. Clause 45 write and read opcodes are 01 and 11.
- R7: A data-register write stores the value and sends a write frame: header, turnaround 10, then the 16 data bits MSB first, all with the output enabled.
- R8: A control write with bit 15 set sends a read frame. The output enable is low through turnaround and data. At the end, data[15:0] holds the 16 sampled bits, MSB first. Bit 15 of control always reads back 0.
- R9: The read-error flag is set when the line is high on the second turnaround bit of a read. It is cleared when the next read launches.
- R10: Busy rises on the edge that accepts a launching write and falls after the last data bit period. Every register write made while busy, including one on the final edge of a frame, is ignored.
- R11: With div equal to 0, no frame is launched, although the written register still stores its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line output value |
| mdio_oe | output | 1 | Line output enable |
| mdio_i | input | 1 | Line input value |

## Verification
Two functions can fall in the same cycle: a frame reaching its final data bit, and software writing a register. On that closing edge the engine is still busy, so the write must be dropped. The write on the very next edge must start a new frame. The bench waits in its own model until the cycle of the last bit, drives a data write exactly there and then another one right after. It judges the result by the data readback, the busy flag and the per-cycle comparison of MDC, the line output and the output enable against its model. A second collision is the read-error set and the data capture within one frame. The bench provokes it by running a read with no responder (line held high), then a read with a responder, and checks that the flag rises and then clears.

// File: rtl/mdio_master_pkg.sv
`timescale 1ns/1ps
package mdio_master_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    typedef enum logic [1:0] {
        OP_ADDR,
        OP_WRITE,
        OP_READ
    } mdio_kind_e;

    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_ADDR = 2'd3;

    localparam int BUSY_BIT  = 31;
    localparam int ERR_BIT   = 30;
    localparam int RD_GO_BIT = 15;

    localparam int HDR_W = 14;
    localparam int PAY_W = 16;

    // last bit index of every phase
    localparam logic [4:0] PRE_LAST  = 5'd31;
    localparam logic [4:0] HDR_LAST  = 5'd13;
    localparam logic [4:0] TA_LAST   = 5'd1;
    localparam logic [4:0] DATA_LAST = 5'd15;

    // {start[1:0], opcode[1:0]}
    function automatic logic [3:0] frame_code(input logic c45, input mdio_kind_e k);
        logic [3:0] code;
        if (c45) begin
            unique case (k)
                OP_ADDR:  code = 4'b0000;
                OP_WRITE: code = 4'b0001;
                default:  code = 4'b0011;
            endcase
        end else begin
            code = (k == OP_READ) ? 4'b0110 : 4'b0101;
        end
        return code;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             bit_end
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;

    assign last_cnt = {div, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == last_cnt) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc     = run && (cnt_q <= {1'b0, div});
    assign bit_end = run && (cnt_q == last_cnt);

endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_master_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  mdio_kind_e       kind,
    input  logic             c45,
    input  logic             pre_sup,
    input  logic [4:0]       phy,
    input  logic [4:0]       dev,
    input  logic [PAY_W-1:0] payload,
    input  logic             bit_end,
    input  logic             mdio_i,
    output logic             busy,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             rd_done,
    output logic [PAY_W-1:0] rd_val,
    output logic             ta_err
);
    mdio_state_e      state_q, state_d;
    logic [4:0]       bcnt_q;
    logic [HDR_W-1:0] hdr_q;
    logic [PAY_W-1:0] dat_q;
    mdio_kind_e       kind_q;
    logic             is_rd;

    assign is_rd = (kind_q == OP_READ);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = pre_sup ? ST_HDR : ST_PRE;
            ST_PRE:  if (bit_end && bcnt_q == PRE_LAST)  state_d = ST_HDR;
            ST_HDR:  if (bit_end && bcnt_q == HDR_LAST)  state_d = ST_TA;
            ST_TA:   if (bit_end && bcnt_q == TA_LAST)   state_d = ST_DATA;
            ST_DATA: if (bit_end && bcnt_q == DATA_LAST) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bcnt_q  <= '0;
            hdr_q   <= '0;
            dat_q   <= '0;
            kind_q  <= OP_ADDR;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && launch) begin
                bcnt_q <= '0;
                hdr_q  <= {frame_code(c45, kind), phy, dev};
                dat_q  <= payload;
                kind_q <= kind;
            end else if (bit_end) begin
                bcnt_q <= (state_d != state_q) ? 5'd0 : bcnt_q + 5'd1;
                if (state_q == ST_HDR) begin
                    hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
                end
                if (state_q == ST_DATA) begin
                    dat_q <= {dat_q[PAY_W-2:0], is_rd ? mdio_i : 1'b0};
                end
            end
        end
    end

    // line outputs
    always_comb begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            ST_HDR: begin
                mdio_oe = 1'b1;
                mdio_o  = hdr_q[HDR_W-1];
            end
            ST_TA: if (!is_rd) begin
                mdio_oe = 1'b1;
                mdio_o  = (bcnt_q == 5'd0);
            end
            ST_DATA: if (!is_rd) begin
                mdio_oe = 1'b1;
                mdio_o  = dat_q[PAY_W-1];
            end
            default: ;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign rd_done = bit_end && is_rd && state_q == ST_DATA && bcnt_q == DATA_LAST;
    assign rd_val  = {dat_q[PAY_W-2:0], mdio_i};
    assign ta_err  = bit_end && is_rd && state_q == ST_TA && bcnt_q == TA_LAST && mdio_i;

endmodule

// File: rtl/mdio_regfile.sv
`timescale 1ns/1ps
module mdio_regfile
    import mdio_master_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy,
    input  logic             rd_done,
    input  logic [PAY_W-1:0] rd_val,
    input  logic             ta_err,
    output logic             launch,
    output mdio_kind_e       kind,
    output logic [DIV_W-1:0] div,
    output logic             pre_sup,
    output logic             c45,
    output logic [4:0]       phy,
    output logic [4:0]       dev,
    output logic [PAY_W-1:0] payload
);
    localparam int PRE_BIT = DIV_W;
    localparam int C45_BIT = DIV_W + 1;

    logic [DIV_W-1:0] div_q;
    logic             pre_q, c45_q, err_q;
    logic [4:0]       phy_q, dev_q;
    logic [PAY_W-1:0] data_q, addr_q;
    logic             accept, div_ok, go_addr, go_wr, go_rd;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[31:16];

    assign accept  = reg_we && !busy;
    assign div_ok  = (div_q != '0);
    assign go_addr = accept && div_ok && reg_sel == SEL_ADDR && c45_q;
    assign go_wr   = accept && div_ok && reg_sel == SEL_DATA;
    assign go_rd   = accept && div_ok && reg_sel == SEL_CTRL && reg_wdata[RD_GO_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            pre_q  <= 1'b0;
            c45_q  <= 1'b0;
            err_q  <= 1'b0;
            phy_q  <= '0;
            dev_q  <= '0;
            data_q <= '0;
            addr_q <= '0;
        end else begin
            if (accept) begin
                unique case (reg_sel)
                    SEL_CFG: begin
                        div_q <= reg_wdata[DIV_W-1:0];
                        pre_q <= reg_wdata[PRE_BIT];
                        c45_q <= reg_wdata[C45_BIT];
                    end
                    SEL_CTRL: begin
                        phy_q <= reg_wdata[4:0];
                        dev_q <= reg_wdata[9:5];
                    end
                    SEL_DATA: data_q <= reg_wdata[PAY_W-1:0];
                    default:  addr_q <= reg_wdata[PAY_W-1:0];
                endcase
            end else if (rd_done) begin
                data_q <= rd_val;
            end
            if (go_rd) begin
                err_q <= 1'b0;
            end else if (ta_err) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CFG: begin
                reg_rdata[DIV_W-1:0] = div_q;
                reg_rdata[PRE_BIT]   = pre_q;
                reg_rdata[C45_BIT]   = c45_q;
                reg_rdata[ERR_BIT]   = err_q;
                reg_rdata[BUSY_BIT]  = busy;
            end
            SEL_CTRL: begin
                reg_rdata[4:0] = phy_q;
                reg_rdata[9:5] = dev_q;
            end
            SEL_DATA: reg_rdata[PAY_W-1:0] = data_q;
            default:  reg_rdata[PAY_W-1:0] = addr_q;
        endcase
    end

    assign launch  = go_addr || go_wr || go_rd;
    assign kind    = (reg_sel == SEL_ADDR) ? OP_ADDR :
                     (reg_sel == SEL_DATA) ? OP_WRITE : OP_READ;
    assign div     = div_q;
    assign pre_sup = pre_q;
    assign c45     = c45_q;
    assign phy     = go_rd ? reg_wdata[4:0] : phy_q;
    assign dev     = go_rd ? reg_wdata[9:5] : dev_q;
    assign payload = reg_wdata[PAY_W-1:0];

endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_master_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             busy_w, launch_w, bit_end_w;
    logic             rd_done_w, ta_err_w;
    logic [PAY_W-1:0] rd_val_w, payload_w;
    mdio_kind_e       kind_w;
    logic [DIV_W-1:0] div_w;
    logic             pre_w, c45_w;
    logic [4:0]       phy_w, dev_w;

    mdio_regfile #(.DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy_w),
        .rd_done   (rd_done_w),
        .rd_val    (rd_val_w),
        .ta_err    (ta_err_w),
        .launch    (launch_w),
        .kind      (kind_w),
        .div       (div_w),
        .pre_sup   (pre_w),
        .c45       (c45_w),
        .phy       (phy_w),
        .dev       (dev_w),
        .payload   (payload_w)
    );

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy_w),
        .div     (div_w),
        .mdc     (mdc),
        .bit_end (bit_end_w)
    );

    mdio_frame_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch_w),
        .kind    (kind_w),
        .c45     (c45_w),
        .pre_sup (pre_w),
        .phy     (phy_w),
        .dev     (dev_w),
        .payload (payload_w),
        .bit_end (bit_end_w),
        .mdio_i  (mdio_i),
        .busy    (busy_w),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_done (rd_done_w),
        .rd_val  (rd_val_w),
        .ta_err  (ta_err_w)
    );

endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk
    import mdio_master_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_oe,
    input logic             reg_we,
    input logic [1:0]       reg_sel,
    input logic [31:0]      reg_rdata,
    input logic [DIV_W-1:0] div,
    input logic             pre,
    input logic             c45
);
    logic [DIV_W:0] hi_run, lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= mdc ? hi_run + 1'b1 : '0;
            lo_run <= (busy && !mdc) ? lo_run + 1'b1 : '0;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R3
    mdc_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_run == {1'b0, div} + 1'b1));

    // R3
    mdc_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mdc) && lo_run != '0) |-> (lo_run == {1'b0, div}));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we) |=> ($stable(div) && $stable(pre) && $stable(c45)));

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we));

    // R11
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && div == '0) |=> !busy);

    // R8
    go_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_CTRL) |-> !reg_rdata[RD_GO_BIT]);

endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_w),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .div       (div_w),
    .pre       (pre_w),
    .c45       (c45_w)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    localparam int DW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_bit = 1'b1;

    assign mdio_i = phy_bit;
    always #2 clk = ~clk;

    mdio_master #(.DIV_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference model
    logic [7:0]  m_div;
    logic        m_pre, m_c45, m_err, m_act, m_rd;
    logic [4:0]  m_phy, m_dev;
    logic [15:0] m_data, m_addr;
    int          m_t, m_P, m_nb, m_ta1;
    int          fb[$];   // 0/1 driven, 2 released
    int          rx[$];   // line value seen by the master
    string       tg[$];
    logic        phy_on = 1'b1;
    logic [15:0] phy_val = '0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic push(int v, int r, string s);
        fb.push_back(v);
        rx.push_back(r);
        tg.push_back(s);
    endtask

    task automatic m_start(int kind); // 0 addr, 1 write, 2 read
        logic [3:0]  code;
        logic [13:0] hdr;
        logic [15:0] pay;
        string       ht, dt;
        fb.delete(); rx.delete(); tg.delete();
        if (!m_pre) for (int i = 0; i < 32; i++) push(1, 1, "R4");
        if (m_c45) code = (kind == 0) ? 4'b0000 : (kind == 1) ? 4'b0001 : 4'b0011;
        else       code = (kind == 2) ? 4'b0110 : 4'b0101;
        hdr = {code, m_phy, m_dev};
        ht = m_c45 ? "R6" : "R5";
        for (int i = 13; i >= 0; i--) push(int'(hdr[i]), 1, ht);
        if (kind == 2) begin
            m_ta1 = fb.size() + 1;
            push(2, 1, "R9");
            push(2, phy_on ? 0 : 1, "R9");
            for (int i = 15; i >= 0; i--) push(2, phy_on ? int'(phy_val[i]) : 1, "R8");
            m_err = 1'b0;
        end else begin
            dt  = (kind == 0) ? "R6" : "R7";
            pay = (kind == 0) ? m_addr : m_data;
            push(1, 1, dt);
            push(0, 1, dt);
            for (int i = 15; i >= 0; i--) push(int'(pay[i]), 1, dt);
        end
        m_rd  = (kind == 2);
        m_P   = 2 * int'(m_div) + 1;
        m_nb  = fb.size();
        m_t   = 0;
        m_act = 1'b1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = '0; m_pre = 0; m_c45 = 0; m_err = 0; m_act = 0; m_rd = 0;
            m_phy = '0; m_dev = '0; m_data = '0; m_addr = '0; m_t = 0;
        end else if (m_act) begin
            if (m_rd && m_t == (m_ta1 + 1) * m_P - 1) m_err = (rx[m_ta1] != 0);
            if (m_t == m_nb * m_P - 1) begin
                m_act = 1'b0;
                if (m_rd) m_data = phy_on ? phy_val : 16'hFFFF;
            end else begin
                m_t++;
            end
        end else if (reg_we) begin
            case (reg_sel)
                2'd0: begin m_div = reg_wdata[7:0]; m_pre = reg_wdata[8]; m_c45 = reg_wdata[9]; end
                2'd1: begin
                    m_phy = reg_wdata[4:0]; m_dev = reg_wdata[9:5];
                    if (reg_wdata[15] && m_div != 0) m_start(2);
                end
                2'd2: begin m_data = reg_wdata[15:0]; if (m_div != 0) m_start(1); end
                default: begin m_addr = reg_wdata[15:0]; if (m_c45 && m_div != 0) m_start(0); end
            endcase
        end
    end

    // responder drive and per-cycle comparison
    always @(negedge clk) begin
        int    bi, ph;
        logic  e_mdc, e_oe, e_o;
        logic [31:0] e_rd;
        string t;
        if (m_act) begin
            bi = m_t / m_P; ph = m_t % m_P;
            phy_bit = (rx[bi] != 0);
            e_mdc = (ph <= int'(m_div));
            e_oe  = (fb[bi] != 2);
            e_o   = (fb[bi] == 1);
            t = tg[bi];
        end else begin
            phy_bit = 1'b1;
            e_mdc = 0; e_oe = 0; e_o = 0;
            t = "R1";
        end
        case (reg_sel)
            2'd0: e_rd = {m_act, m_err, 20'd0, m_c45, m_pre, m_div};
            2'd1: e_rd = {22'd0, m_dev, m_phy};
            2'd2: e_rd = {16'd0, m_data};
            default: e_rd = {16'd0, m_addr};
        endcase
        if (rst_n) begin
            chk(m_act ? "R3" : "R1", "mdc", {31'd0, mdc}, {31'd0, e_mdc});
            chk(t, "mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
            chk(t, "mdio_o", {31'd0, mdio_o}, {31'd0, e_o});
            chk("R2", "reg_rdata", reg_rdata, e_rd);
        end
    end

    task automatic wr(logic [1:0] s, logic [31:0] d);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    endtask

    task automatic rdchk(logic [1:0] s, logic [31:0] e, string req, string what);
        reg_sel = s;
        #0.5;
        chk(req, what, reg_rdata, e);
        reg_sel = 2'd0;
    endtask

    task automatic wait_idle();
        do begin @(posedge clk); #1; end while (m_act);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                summary();
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        // R1 reset state
        rdchk(2'd0, 32'h0, "R1", "cfg after reset");
        rdchk(2'd1, 32'h0, "R1", "ctrl after reset");
        rdchk(2'd2, 32'h0, "R1", "data after reset");
        rdchk(2'd3, 32'h0, "R1", "addr after reset");
        chk("R1", "mdc after reset", {31'd0, mdc}, 32'd0);

        // R11 zero divider: stored, no frame
        wr(2'd2, 32'h0000_1234);
        rdchk(2'd0, 32'h0, "R11", "busy with div 0");
        rdchk(2'd2, 32'h0000_1234, "R11", "data stored with div 0");
        wr(2'd1, 32'h0000_8000);
        rdchk(2'd0, 32'h0, "R11", "read-go with div 0");

        // R5 R7 Clause 22 write, div 1
        wr(2'd0, 32'h0000_0001);
        wr(2'd1, 32'h0000_0145);          // port 5, reg 10
        rdchk(2'd1, 32'h0000_0145, "R2", "ctrl readback");
        wr(2'd2, 32'h0000_A5C3);
        rdchk(2'd0, 32'h8000_0001, "R10", "busy after launch");
        // R10 writes during busy ignored
        repeat (5) begin @(posedge clk); #1; end
        wr(2'd0, 32'h0000_0303);
        wr(2'd1, 32'h0000_03FF);
        wr(2'd3, 32'h0000_4444);
        wait_idle();
        rdchk(2'd0, 32'h0000_0001, "R10", "cfg kept during busy");
        rdchk(2'd1, 32'h0000_0145, "R10", "ctrl kept during busy");
        rdchk(2'd3, 32'h0000_0000, "R10", "addr kept during busy");

        // R8 Clause 22 read with responder
        phy_on = 1'b1; phy_val = 16'h3C96;
        wr(2'd1, 32'h0000_80A3);
        wait_idle();
        rdchk(2'd2, 32'h0000_3C96, "R8", "read data");
        rdchk(2'd0, 32'h0000_0001, "R9", "no read error");
        rdchk(2'd1, 32'h0000_00A3, "R8", "read-go reads 0");

        // R4 preamble suppressed
        wr(2'd0, 32'h0000_0101);
        wr(2'd2, 32'h0000_5A0F);
        wait_idle();

        // R6 Clause 45 address, write, read, div 2
        wr(2'd0, 32'h0000_0202);
        wr(2'd1, 32'h0000_0067);
        wr(2'd3, 32'h0000_0123);
        rdchk(2'd0, 32'h8000_0202, "R6", "busy on address frame");
        wait_idle();
        wr(2'd2, 32'h0000_C0DE);
        wait_idle();
        phy_val = 16'hBEEF;
        wr(2'd1, 32'h0000_8067);
        wait_idle();
        rdchk(2'd2, 32'h0000_BEEF, "R8", "c45 read data");

        // R9 read with no responder, then cleared
        phy_on = 1'b0;
        wr(2'd1, 32'h0000_8067);
        wait_idle();
        rdchk(2'd0, 32'h4000_0202, "R9", "read error set");
        rdchk(2'd2, 32'h0000_FFFF, "R9", "data with no responder");
        phy_on = 1'b1; phy_val = 16'h0F1E;
        wr(2'd1, 32'h0000_8067);
        rdchk(2'd0, 32'h8000_0202, "R9", "error cleared at launch");
        wait_idle();

        // R6 address write in Clause 22 mode only stores
        wr(2'd0, 32'h0000_0001);
        wr(2'd3, 32'h0000_7E57);
        rdchk(2'd0, 32'h0000_0001, "R6", "no frame in c22 address write");
        rdchk(2'd3, 32'h0000_7E57, "R6", "address stored");

        // R10 write on the final edge of a frame, then one right after
        wr(2'd2, 32'h0000_0F0F);
        do begin @(posedge clk); #1; end while (!(m_act && m_t == m_nb * m_P - 1));
        wr(2'd2, 32'h0000_7777);
        rdchk(2'd2, 32'h0000_0F0F, "R10", "write on final edge ignored");
        rdchk(2'd0, 32'h0000_0001, "R10", "idle after final edge");
        wr(2'd2, 32'h0000_1111);
        rdchk(2'd0, 32'h8000_0001, "R10", "write after final edge launches");
        wait_idle();

        // R3 wider divider
        wr(2'd0, 32'h0000_0003);
        wr(2'd2, 32'h0000_9669);
        wait_idle();
        repeat (4) begin @(posedge clk); #1; end

        summary();
        $finish;
    end
endmodule